// File: doc/BRIEF.md
# Byte-Addressed Memory with Address and Buffer Registers

This block is a small synchronous memory that is reached only through two registers. The address register holds the location of the next access. The buffer register holds the data that goes into memory on a write, and it receives the data that comes out on a read. Both registers have their own load ports. A processor-side sequencer first loads the address register, and the buffer register too for a write. It then pulses the active-low select with the read/write-low line set to the wanted direction.

Storage is an internal byte array. An access moves one byte, a 16-bit halfword or a 32-bit word. A multi-byte access uses the consecutive byte addresses that start at the address register, and it wraps modulo the memory size. A mode input sets the byte order. In big-endian order the lowest address holds the most significant byte. In little-endian order it holds the least significant byte. The depth must be a power of two of at least four bytes.

Top module: `byte_mem_unit`

## Requirements
- R1: While `selN` is 1, no byte of storage changes and the buffer register keeps its value, whatever the level of `rwN`.
- R2: With `selN`=0 and `rwN`=0 on a clock edge, the buffer register contents are stored at the bytes starting at the address register.
- R3: With `selN`=0 and `rwN`=1 on a clock edge, the addressed bytes are placed into the buffer register at that edge, so they are visible on `mbrOut` one clock after the request.
- R4: `accSize` 2'b00 moves one byte at address A. 2'b01 moves bytes A and A+1. 2'b10 and 2'b11 move bytes A to A+3.
- R5: With `bigEndian`=1, the byte at the lowest address is the most significant byte of the transferred value (bits [8n-1:8n-8] for an n-byte access).
- R6: With `bigEndian`=0, the byte at the lowest address is the least significant byte (bits [7:0]) of the transferred value.
- R7: A byte or halfword read clears the unused upper bits of the buffer register. A byte or halfword write uses only the low 8 or 16 bits of the buffer register and leaves every other byte of storage unchanged.
- R8: An access whose bytes run past the top address continues at address 0, modulo the memory depth.
- R9: `marLoad` and `mbrLoad` load their registers at the clock edge, and the registers otherwise hold. When a read and `mbrLoad` occur in the same cycle, the read data wins.
- R10: After reset, the buffer register output reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset of the address and buffer registers |
| marLoad | input | 1 | Load `marIn` into the address register |
| marIn | input | ADDR_W | New address register value |
| mbrLoad | input | 1 | Load `mbrIn` into the buffer register |
| mbrIn | input | 32 | New buffer register value |
| accSize | input | 2 | Transfer size: 00 byte, 01 halfword, 10/11 word |
| bigEndian | input | 1 | 1 big-endian byte order, 0 little-endian |
| selN | input | 1 | Active-low select |
| rwN | input | 1 | 1 read, 0 write |
| mbrOut | output | 32 | Buffer register contents |

## Verification
The bench fills the whole array with an arithmetic byte pattern. It then reads every address in every size and in both byte orders. This catches swapped lanes, a missing zero extension and a last-address access that fails to wrap to 0 (such a design would return bytes from past the top of storage or garbage). Narrow writes are followed by reads of the neighbouring bytes, so a design that writes a full word for every size corrupts data beside the target. Select-high cycles with both directions show whether a design that ignores the select changes storage or the buffer. A read issued together with a buffer load shows whether the design lets the load overwrite the read data.

// File: rtl/bytemem_pkg.sv
package bytemem_pkg;

  localparam int LANES = 4;
  localparam int DATA_W = 8 * LANES;

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10,
    SZ_WORD_ALT = 2'b11
  } accSize_e;

  typedef struct packed {
    logic             rdEn;
    logic             wrEn;
    logic             bigEnd;
    logic [LANES-1:0] laneEn;
    logic [1:0]       topIdx;
  } memStrobe_t;

endpackage

// File: rtl/mem_ctrl.sv
module mem_ctrl
  import bytemem_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       selN,
  input  logic       rwN,
  input  logic [1:0] accSize,
  input  logic       bigEndian,
  output memStrobe_t strb
);

  logic selected;
  assign selected = !selN;

  always_comb begin
    strb = '0;
    strb.rdEn = selected && rwN;
    strb.wrEn = selected && !rwN;
    strb.bigEnd = bigEndian;
    case (accSize_e'(accSize))
      SZ_BYTE: begin
        strb.laneEn = 4'b0001;
        strb.topIdx = 2'd0;
      end
      SZ_HALF: begin
        strb.laneEn = 4'b0011;
        strb.topIdx = 2'd1;
      end
      default: begin
        strb.laneEn = 4'b1111;
        strb.topIdx = 2'd3;
      end
    endcase
  end

  // R4
  lane_count_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn || strb.wrEn) |-> ($countones(strb.laneEn) == int'(strb.topIdx) + 1));

  // R2
  dir_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.rdEn, strb.wrEn}));

endmodule

// File: rtl/mem_datapath.sv
module mem_datapath
  import bytemem_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              marLoad,
  input  logic [AW-1:0]     marIn,
  input  logic              mbrLoad,
  input  logic [DATA_W-1:0] mbrIn,
  input  memStrobe_t        strb,
  output logic [DATA_W-1:0] mbrOut
);

  logic [AW-1:0]     mar;
  logic [DATA_W-1:0] mbr;
  logic [7:0]        store [DEPTH];

  logic [AW-1:0] laneAddr [LANES];
  logic [7:0]    rdByte   [LANES];
  logic [7:0]    wrByte   [LANES];
  logic [1:0]    posIdx   [LANES];
  logic [DATA_W-1:0] rdWord;

  // Per-lane address and its slot in the transferred value
  for (genvar k = 0; k < LANES; k++) begin : g_lane
    assign laneAddr[k] = mar + AW'(k);
    assign rdByte[k]   = store[laneAddr[k]];
    assign posIdx[k]   = strb.bigEnd ? 2'(strb.topIdx - 2'(k)) : 2'(k);
    assign wrByte[k]   = mbr[8*posIdx[k] +: 8];
  end

  always_comb begin
    rdWord = '0;
    for (int k = 0; k < LANES; k++) begin
      if (strb.laneEn[k]) rdWord[8*posIdx[k] +: 8] = rdByte[k];
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < LANES; k++) begin
      if (strb.wrEn && strb.laneEn[k]) store[laneAddr[k]] <= wrByte[k];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) mar <= '0;
    else if (marLoad) mar <= marIn;
  end

  always_ff @(posedge clk) begin
    if (!rstN) mbr <= '0;
    else if (strb.rdEn) mbr <= rdWord;
    else if (mbrLoad) mbr <= mbrIn;
  end

  assign mbrOut = mbr;

  // R9
  mar_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !marLoad |=> $stable(mar));

  // R9
  mbr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!mbrLoad && !strb.rdEn) |=> $stable(mbr));

  // R7
  narrow_zext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && !strb.laneEn[2]) |=> (mbr[31:16] == 16'h0));

  // R7
  byte_zext_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdEn && !strb.laneEn[1]) |=> (mbr[15:8] == 8'h0));

endmodule

// File: rtl/byte_mem_unit.sv
module byte_mem_unit
  import bytemem_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int ADDR_W = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              marLoad,
  input  logic [ADDR_W-1:0] marIn,
  input  logic              mbrLoad,
  input  logic [31:0]       mbrIn,
  input  logic [1:0]        accSize,
  input  logic              bigEndian,
  input  logic              selN,
  input  logic              rwN,
  output logic [31:0]       mbrOut
);

  memStrobe_t strb;

  mem_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .selN(selN), .rwN(rwN),
    .accSize(accSize), .bigEndian(bigEndian), .strb(strb)
  );

  mem_datapath #(.DEPTH(DEPTH)) u_dp (
    .clk(clk), .rstN(rstN), .marLoad(marLoad), .marIn(marIn),
    .mbrLoad(mbrLoad), .mbrIn(mbrIn), .strb(strb), .mbrOut(mbrOut)
  );

  // R1
  desel_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    selN |-> !(strb.rdEn || strb.wrEn));

endmodule

// File: tb/tb_byte_mem_unit.sv
module tb_byte_mem_unit;

  localparam int DEPTH = 256;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic marLoad = 1'b0;
  logic [AW-1:0] marIn = '0;
  logic mbrLoad = 1'b0;
  logic [31:0] mbrIn = '0;
  logic [1:0] accSize = 2'b00;
  logic bigEndian = 1'b0;
  logic selN = 1'b1;
  logic rwN = 1'b1;
  logic [31:0] mbrOut;

  int checks = 0;
  int fails = 0;
  logic [7:0] model [DEPTH];

  always #2 clk = ~clk;

  byte_mem_unit #(.DEPTH(DEPTH)) dut (
    .clk(clk), .rstN(rstN), .marLoad(marLoad), .marIn(marIn),
    .mbrLoad(mbrLoad), .mbrIn(mbrIn), .accSize(accSize),
    .bigEndian(bigEndian), .selN(selN), .rwN(rwN), .mbrOut(mbrOut)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  function automatic int nBytes(input logic [1:0] sz);
    return (sz == 2'b00) ? 1 : (sz == 2'b01) ? 2 : 4;
  endfunction

  function automatic logic [31:0] expRead(input int a, input logic [1:0] sz, input logic be);
    logic [31:0] v = '0;
    int n = nBytes(sz);
    for (int k = 0; k < n; k++) begin
      int p = be ? (n - 1 - k) : k;
      v[8*p +: 8] = model[(a + k) % DEPTH];
    end
    return v;
  endfunction

  task automatic doWrite(input int a, input logic [31:0] d, input logic [1:0] sz, input logic be);
    int n = nBytes(sz);
    @(negedge clk);
    marLoad = 1'b1; marIn = AW'(a); mbrLoad = 1'b1; mbrIn = d;
    @(negedge clk);
    marLoad = 1'b0; mbrLoad = 1'b0;
    selN = 1'b0; rwN = 1'b0; accSize = sz; bigEndian = be;
    @(negedge clk);
    selN = 1'b1; rwN = 1'b1;
    for (int k = 0; k < n; k++) begin
      int p = be ? (n - 1 - k) : k;
      model[(a + k) % DEPTH] = d[8*p +: 8];
    end
  endtask

  task automatic doRead(input int a, input logic [1:0] sz, input logic be, output logic [31:0] got);
    @(negedge clk);
    marLoad = 1'b1; marIn = AW'(a);
    @(negedge clk);
    marLoad = 1'b0;
    selN = 1'b0; rwN = 1'b1; accSize = sz; bigEndian = be;
    @(negedge clk);
    selN = 1'b1;
    got = mbrOut;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual hung expected finished");
    finishRun();
  end

  initial begin
    logic [31:0] got;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 reset buffer", mbrOut, 32'h0);
    rstN = 1'b1;

    // R2 fill every byte with an arithmetic pattern
    for (int a = 0; a < DEPTH; a++) doWrite(a, 32'(((a * 7 + 3) & 8'hFF) | 32'hABCD_EF00), 2'b00, 1'b0);

    // R3 R4 R5 R6 R7 R8 full sweep of address, size and order
    for (int a = 0; a < DEPTH; a++) begin
      for (int s = 0; s < 3; s++) begin
        for (int e = 0; e < 2; e++) begin
          string tag;
          doRead(a, 2'(s), e[0], got);
          tag = (s == 0) ? "R7 R4 byte read" : (e == 1) ? "R5 R3 big-endian read" : "R6 R3 little-endian read";
          chk(tag, got, expRead(a, 2'(s), e[0]));
        end
      end
    end

    // R5 R6 fixed byte-order example
    doWrite(8'h40, 32'h11, 2'b00, 1'b0);
    doWrite(8'h41, 32'h22, 2'b00, 1'b0);
    doWrite(8'h42, 32'h33, 2'b00, 1'b0);
    doWrite(8'h43, 32'h44, 2'b00, 1'b0);
    doRead(8'h40, 2'b10, 1'b1, got); chk("R5 word big-endian", got, 32'h1122_3344);
    doRead(8'h40, 2'b10, 1'b0, got); chk("R6 word little-endian", got, 32'h4433_2211);
    doRead(8'h40, 2'b01, 1'b1, got); chk("R5 half big-endian", got, 32'h0000_1122);
    doRead(8'h40, 2'b01, 1'b0, got); chk("R6 half little-endian", got, 32'h0000_2211);
    doRead(8'h40, 2'b11, 1'b1, got); chk("R4 size 11 is word", got, 32'h1122_3344);

    // R7 narrow writes leave neighbours alone
    doWrite(8'h60, 32'h1234_BEEF, 2'b01, 1'b1);
    doRead(8'h60, 2'b00, 1'b0, got); chk("R5 half write low addr", got, 32'hBE);
    doRead(8'h61, 2'b00, 1'b0, got); chk("R5 half write next addr", got, 32'hEF);
    doRead(8'h62, 2'b00, 1'b0, got); chk("R7 half write neighbour", got, expRead(8'h62, 2'b00, 1'b0));
    doRead(8'h5F, 2'b00, 1'b0, got); chk("R7 half write below", got, expRead(8'h5F, 2'b00, 1'b0));
    doWrite(8'h70, 32'hFFFF_FF5A, 2'b00, 1'b1);
    doRead(8'h70, 2'b10, 1'b0, got); chk("R7 byte write word view", got, expRead(8'h70, 2'b10, 1'b0));

    // R8 wrapping writes and reads
    doWrite(8'hFE, 32'hA1B2_C3D4, 2'b10, 1'b0);
    doRead(8'h00, 2'b00, 1'b0, got); chk("R8 wrap byte at 0", got, 32'hB2);
    doRead(8'h01, 2'b00, 1'b0, got); chk("R8 wrap byte at 1", got, 32'hA1);
    doRead(8'hFF, 2'b10, 1'b1, got); chk("R8 wrap word read", got, expRead(8'hFF, 2'b10, 1'b1));

    // R1 deselected cycles in both directions
    @(negedge clk);
    marLoad = 1'b1; marIn = 8'h10; mbrLoad = 1'b1; mbrIn = 32'hA5A5_A5A5;
    @(negedge clk);
    marLoad = 1'b0; mbrLoad = 1'b0; selN = 1'b1; rwN = 1'b0; accSize = 2'b10;
    @(negedge clk);
    rwN = 1'b1;
    @(negedge clk);
    chk("R1 buffer unchanged while deselected", mbrOut, 32'hA5A5_A5A5);
    for (int k = 0; k < 4; k++) begin
      doRead(8'h10 + k, 2'b00, 1'b0, got);
      chk("R1 storage unchanged while deselected", got, expRead(8'h10 + k, 2'b00, 1'b0));
    end

    // R9 buffer load alone, then read competing with a load
    @(negedge clk);
    mbrLoad = 1'b1; mbrIn = 32'h0BAD_F00D;
    @(negedge clk);
    mbrLoad = 1'b0;
    chk("R9 buffer load", mbrOut, 32'h0BAD_F00D);
    @(negedge clk);
    marLoad = 1'b1; marIn = 8'h40;
    @(negedge clk);
    marLoad = 1'b0; mbrLoad = 1'b1; mbrIn = 32'hFFFF_FFFF;
    selN = 1'b0; rwN = 1'b1; accSize = 2'b10; bigEndian = 1'b1;
    @(negedge clk);
    mbrLoad = 1'b0; selN = 1'b1;
    chk("R9 read wins over load", mbrOut, 32'h1122_3344);

    finishRun();
  end

endmodule